// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps a dynamic memory's contents alive. After reset it holds every strobe inactive for a programmable power-up pause. It then runs a fixed number of CAS-before-RAS refresh sequences on its own, with no grant needed, and raises `init_done`. The memory's internal row counter picks the row, so the block drives no address.

Once initialised, an interval timer expires every `INTERVAL_CLKS` cycles. Set this to the retention period divided by 512 rows, in clocks. Each expiry adds one owed refresh to a saturating tally, and `rfsh_req` stays high while anything is owed. The access controller answers with `gnt`. On a clock edge where a request is pending, `gnt` is high and no sequence is running, the block starts a sequence, takes ownership of the strobes (`busy`) and retires one owed refresh.

If the tally is already full when another interval expires and no refresh is being taken, a sticky `overdue` flag is set. Only reset clears it.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While `rst` is high and after it is released, `cas_n` = 2'b11, `ras_n` = 1, and `rfsh_req`, `init_done`, `busy` and `overdue` are all 0. The first CAS fall appears on the output after clock edge PAUSE_CLKS+1 counted from reset release.
- R2: After the pause, exactly INIT_CYCLES sequences run with no grant, back to back with one idle cycle between them. `init_done` rises one cycle after `busy` falls at the end of the last one and then stays high.
- R3: Each sequence has three phases with no other strobe state in between. First, both CAS lanes are low with `ras_n` high for CSR_CLKS cycles. Next, CAS and RAS are both low for RAS_LOW_CLKS cycles. Last, all strobes are high for PRECHARGE_CLKS cycles. RAS never falls unless CAS was already low, and CAS never falls unless RAS has been high for at least PRECHARGE_CLKS cycles.
- R4: `ras_n` is never low for more than RAS_LOW_CLKS consecutive cycles.
- R5: `rfsh_req` is 0 before `init_done`. After `init_done` rises, an interval expires on the INTERVAL_CLKS-th edge and on every INTERVAL_CLKS-th edge after that. Each expiry adds one owed refresh, and `rfsh_req` is 1 exactly while the owed count is nonzero.
- R6: A sequence starts on an edge where `rfsh_req`, `gnt` and not `busy` all hold, and each start retires one owed refresh. `busy` is 1 for the whole sequence. When `rfsh_req` is 0 or `busy` is 1, `gnt` has no effect.
- R7: The owed count saturates at OVERDUE_LIM. An expiry that finds the count at OVERDUE_LIM with no start on the same edge sets `overdue`, which holds until reset.
- R8: `we_n` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gnt | input | 1 | Controller permits a refresh to start |
| rfsh_req | output | 1 | At least one refresh is owed |
| init_done | output | 1 | Pause and initial sequences complete |
| busy | output | 1 | Refresh sequence owns the strobes |
| overdue | output | 1 | Sticky: owed refreshes overflowed |
| cas_n | output | 2 | Column strobes for both byte lanes, active low |
| ras_n | output | 1 | Row strobe, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The bench targets the following corner cases:
- **Pause length and initial sequence count.** A design off by one here would start early or issue seven or nine initial cycles.
- **The idle cycle between back-to-back sequences.** Skipping it would shorten precharge below its minimum.
- **A grant that lands while a sequence is running.** If this grant were honoured, the strobes would glitch.
- **An interval that expires on the same edge a refresh is taken.** A design that got the tally wrong here would lose or double a request.
- **Starving the block of grants until the tally saturates.** A design that got this wrong would never raise `overdue`, or would let it drop again once the backlog drains.

The exact RAS-low run length is measured directly, because a sequencer that overstays RAS could push the memory into its self-refresh behaviour.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_PRECH
  } seq_phase_e;

  typedef enum logic [1:0] {
    ST_PAUSE,
    ST_INIT,
    ST_RUN
  } sched_state_e;

  // Bits needed to hold values 0..n
  function automatic int unsigned w_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
  import cbr_refresh_pkg::*;
#(
  parameter int unsigned T_CSR = 3,
  parameter int unsigned T_ACT = 18,
  parameter int unsigned T_PRE = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic cas_q,
  output logic ras_q,
  output logic busy
);

  localparam int unsigned T_MAX = (T_CSR > T_ACT) ? ((T_CSR > T_PRE) ? T_CSR : T_PRE)
                                                  : ((T_ACT > T_PRE) ? T_ACT : T_PRE);
  localparam int unsigned CW = w_for(T_MAX - 1);

  seq_phase_e    phase, phase_nxt;
  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    phase_nxt = phase;
    cnt_nxt   = cnt + 1'b1;
    unique case (phase)
      PH_IDLE: begin
        cnt_nxt = '0;
        if (start) phase_nxt = PH_SETUP;
      end
      PH_SETUP: if (cnt == CW'(T_CSR - 1)) begin
        phase_nxt = PH_ACTIVE;
        cnt_nxt   = '0;
      end
      PH_ACTIVE: if (cnt == CW'(T_ACT - 1)) begin
        phase_nxt = PH_PRECH;
        cnt_nxt   = '0;
      end
      PH_PRECH: if (cnt == CW'(T_PRE - 1)) begin
        phase_nxt = PH_IDLE;
        cnt_nxt   = '0;
      end
      default: begin
        phase_nxt = PH_IDLE;
        cnt_nxt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      cas_q <= 1'b1;
      ras_q <= 1'b1;
      busy  <= 1'b0;
    end else begin
      phase <= phase_nxt;
      cnt   <= cnt_nxt;
      cas_q <= !((phase_nxt == PH_SETUP) || (phase_nxt == PH_ACTIVE));
      ras_q <= (phase_nxt != PH_ACTIVE);
      busy  <= (phase_nxt != PH_IDLE);
    end
  end

endmodule

// File: rtl/cbr_init_ctrl.sv
module cbr_init_ctrl
  import cbr_refresh_pkg::*;
#(
  parameter int unsigned PAUSE_CLKS  = 25000,
  parameter int unsigned INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic seq_busy,
  output logic start_init,
  output logic init_done
);

  localparam int unsigned PW = w_for(PAUSE_CLKS - 1);
  localparam int unsigned IW = w_for(INIT_CYCLES);

  sched_state_e  st;
  logic [PW-1:0] pause_cnt;
  logic [IW-1:0] issued;

  assign start_init = (st == ST_INIT) && !seq_busy && (issued != IW'(INIT_CYCLES));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_PAUSE;
      pause_cnt <= '0;
      issued    <= '0;
      init_done <= 1'b0;
    end else begin
      unique case (st)
        ST_PAUSE: begin
          if (pause_cnt == PW'(PAUSE_CLKS - 1)) st <= ST_INIT;
          else                                  pause_cnt <= pause_cnt + 1'b1;
        end
        ST_INIT: begin
          if (start_init) begin
            issued <= issued + 1'b1;
          end else if (!seq_busy) begin
            st        <= ST_RUN;
            init_done <= 1'b1;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end

endmodule

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer
  import cbr_refresh_pkg::*;
#(
  parameter int unsigned INTERVAL_CLKS = 3906,
  parameter int unsigned OVERDUE_LIM   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic take,
  output logic req,
  output logic overdue
);

  localparam int unsigned VW = w_for(INTERVAL_CLKS - 1);
  localparam int unsigned OW = w_for(OVERDUE_LIM);

  logic [VW-1:0] ivl;
  logic [OW-1:0] owed, owed_nxt;
  logic          tick, at_lim;

  assign tick   = enable && (ivl == VW'(INTERVAL_CLKS - 1));
  assign at_lim = (owed == OW'(OVERDUE_LIM));

  always_comb begin
    owed_nxt = owed;
    if (tick && !take) begin
      if (!at_lim) owed_nxt = owed + 1'b1;
    end else if (take && !tick) begin
      owed_nxt = owed - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ivl     <= '0;
      owed    <= '0;
      req     <= 1'b0;
      overdue <= 1'b0;
    end else begin
      if (enable) ivl <= tick ? '0 : ivl + 1'b1;
      owed    <= owed_nxt;
      req     <= (owed_nxt != '0);
      overdue <= overdue | (tick && !take && at_lim);
    end
  end

endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched #(
  parameter int unsigned PAUSE_CLKS     = 25000,
  parameter int unsigned INIT_CYCLES    = 8,
  parameter int unsigned INTERVAL_CLKS  = 3906,
  parameter int unsigned CSR_CLKS       = 3,
  parameter int unsigned RAS_LOW_CLKS   = 18,
  parameter int unsigned PRECHARGE_CLKS = 13,
  parameter int unsigned OVERDUE_LIM    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gnt,
  output logic       rfsh_req,
  output logic       init_done,
  output logic       busy,
  output logic       overdue,
  output logic [1:0] cas_n,
  output logic       ras_n,
  output logic       we_n
);

  logic start_init, run_take, seq_start, cas_q;

  assign run_take  = init_done && rfsh_req && gnt && !busy;
  assign seq_start = start_init | run_take;

  cbr_init_ctrl #(
    .PAUSE_CLKS (PAUSE_CLKS),
    .INIT_CYCLES(INIT_CYCLES)
  ) u_init (
    .clk       (clk),
    .rst       (rst),
    .seq_busy  (busy),
    .start_init(start_init),
    .init_done (init_done)
  );

  cbr_interval_timer #(
    .INTERVAL_CLKS(INTERVAL_CLKS),
    .OVERDUE_LIM  (OVERDUE_LIM)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .enable (init_done),
    .take   (run_take),
    .req    (rfsh_req),
    .overdue(overdue)
  );

  cbr_strobe_seq #(
    .T_CSR(CSR_CLKS),
    .T_ACT(RAS_LOW_CLKS),
    .T_PRE(PRECHARGE_CLKS)
  ) u_seq (
    .clk  (clk),
    .rst  (rst),
    .start(seq_start),
    .cas_q(cas_q),
    .ras_q(ras_n),
    .busy (busy)
  );

  assign cas_n = {2{cas_q}};
  assign we_n  = 1'b1;

endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk
  import cbr_refresh_pkg::*;
#(
  parameter int unsigned T_RAS = 18,
  parameter int unsigned T_RP  = 13
) (
  input logic       clk,
  input logic       rst,
  input logic       rfsh_req,
  input logic       init_done,
  input logic       busy,
  input logic       overdue,
  input logic [1:0] cas_n,
  input logic       ras_n
);

  localparam int unsigned LW = w_for(T_RAS + 1);
  localparam int unsigned HW = w_for(T_RP + 1);

  logic [LW-1:0] lo_run;
  logic [HW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_run <= '0;
      hi_run <= HW'(T_RP + 1);
    end else begin
      if (ras_n) lo_run <= '0;
      else if (lo_run != LW'(T_RAS + 1)) lo_run <= lo_run + 1'b1;
      if (!ras_n) hi_run <= '0;
      else if (hi_run != HW'(T_RP + 1)) hi_run <= hi_run + 1'b1;
    end
  end

  AST_RAS_WITH_CAS: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> (cas_n == 2'b00)); // R3
  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $past(cas_n == 2'b00)); // R3
  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n[0]) |-> (ras_n && (hi_run >= HW'(T_RP)))); // R3
  AST_RAS_MAX: assert property (@(posedge clk) disable iff (rst)
    lo_run <= LW'(T_RAS)); // R4
  AST_NO_REQ_BEFORE_INIT: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !rfsh_req); // R5
  AST_INIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done); // R2
  AST_STROBES_OWNED: assert property (@(posedge clk) disable iff (rst)
    (cas_n != 2'b11) |-> busy); // R6
  AST_OVERDUE_STICKY: assert property (@(posedge clk) disable iff (rst)
    overdue |=> overdue); // R7

endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk #(
  .T_RAS(RAS_LOW_CLKS),
  .T_RP (PRECHARGE_CLKS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rfsh_req (rfsh_req),
  .init_done(init_done),
  .busy     (busy),
  .overdue  (overdue),
  .cas_n    (cas_n),
  .ras_n    (ras_n)
);

// File: tb/cbr_refresh_sched_tb.sv
`timescale 1ns/1ps
module cbr_refresh_sched_tb;

  localparam int PAUSE = 40;
  localparam int NINIT = 8;
  localparam int INTV  = 30;
  localparam int CSR   = 2;
  localparam int RASL  = 4;
  localparam int RP    = 3;
  localparam int LIM   = 3;
  localparam int SEQ_LEN = CSR + RASL + RP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gnt = 1'b1;
  logic rfsh_req, init_done, busy, overdue, ras_n, we_n;
  logic [1:0] cas_n;

  always #2 clk = ~clk;

  cbr_refresh_sched #(
    .PAUSE_CLKS(PAUSE), .INIT_CYCLES(NINIT), .INTERVAL_CLKS(INTV),
    .CSR_CLKS(CSR), .RAS_LOW_CLKS(RASL), .PRECHARGE_CLKS(RP), .OVERDUE_LIM(LIM)
  ) u_dut (
    .clk(clk), .rst(rst), .gnt(gnt), .rfsh_req(rfsh_req), .init_done(init_done),
    .busy(busy), .overdue(overdue), .cas_n(cas_n), .ras_n(ras_n), .we_n(we_n)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  int m_st, m_pcnt, m_iss, m_seq, m_ivl, m_owed;
  bit m_done, m_req, m_over, bsy, go, tick, take;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_pcnt = 0; m_iss = 0; m_seq = -1; m_ivl = 0; m_owed = 0;
      m_done = 0; m_req = 0; m_over = 0;
    end else begin
      bsy = (m_seq >= 0);
      go  = 0;
      if (m_st == 0) begin
        if (m_pcnt == PAUSE - 1) m_st = 1; else m_pcnt++;
      end else if (m_st == 1) begin
        if (!bsy && m_iss < NINIT) begin go = 1; m_iss++; end
        else if (!bsy) begin m_st = 2; m_done = 1; end
      end else begin
        tick  = (m_ivl == INTV - 1);
        m_ivl = tick ? 0 : m_ivl + 1;
        take  = m_req && gnt && !bsy;
        if (take) go = 1;
        if (tick && !take) begin
          if (m_owed == LIM) m_over = 1; else m_owed++;
        end else if (take && !tick) m_owed--;
        m_req = (m_owed != 0);
      end
      if (go) m_seq = 0;
      else if (m_seq >= 0) m_seq = (m_seq == SEQ_LEN - 1) ? -1 : m_seq + 1;
    end
  end

  // Port observers
  int cyc = 0;
  int first_cas = -1;
  int init_falls = 0;
  int win_falls = 0;
  bit win_on = 0;
  int lo_run = 0;
  int lo_max = 0;
  bit prev_cas = 1;

  always @(posedge clk) if (!rst) cyc++;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      automatic bit e_cas = !(m_seq >= 0 && m_seq < CSR + RASL);
      automatic bit e_ras = !(m_seq >= CSR && m_seq < CSR + RASL);
      chk(cas_n == {2{e_cas}}, "R3 cas_n", cas_n, {2{e_cas}});
      chk(ras_n == e_ras, "R3 ras_n", ras_n, e_ras);
      chk(busy == (m_seq >= 0), "R6 busy", busy, m_seq >= 0);
      chk(rfsh_req == m_req, "R5 rfsh_req", rfsh_req, m_req);
      chk(init_done == m_done, "R2 init_done", init_done, m_done);
      chk(overdue == m_over, "R7 overdue", overdue, m_over);
      chk(we_n == 1'b1, "R8 we_n", we_n, 1);
      if (prev_cas && !cas_n[0]) begin
        if (first_cas < 0) first_cas = cyc;
        if (!init_done) init_falls++;
        if (win_on) win_falls++;
      end
      prev_cas = cas_n[0];
      lo_run = ras_n ? 0 : lo_run + 1;
      if (lo_run > lo_max) lo_max = lo_run;
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cas_n == 2'b11 && ras_n && we_n, "R1 strobes in reset", {cas_n, ras_n}, 7);
    chk(!rfsh_req && !init_done && !busy && !overdue, "R1 flags in reset",
        {rfsh_req, init_done, busy, overdue}, 0);
    rst = 1'b0;
    gnt = 1'b1;  // grant during pause/init must be irrelevant
    while (!init_done) @(negedge clk);
    chk(first_cas == PAUSE + 1, "R1 pause length", first_cas, PAUSE + 1);
    chk(init_falls == NINIT, "R2 initial sequence count", init_falls, NINIT);
    chk(rfsh_req == 1'b0, "R5 no request at init_done", rfsh_req, 0);

    // steady grant: every interval is serviced
    repeat (5 * INTV) @(negedge clk);
    chk(!overdue, "R7 no overdue with prompt grants", overdue, 0);

    // starve the block of grants
    gnt = 1'b0;
    win_on = 1;
    win_falls = 0;
    repeat ((LIM + 2) * INTV) @(negedge clk);
    chk(win_falls == 0, "R6 no sequence without grant", win_falls, 0);
    chk(rfsh_req == 1'b1, "R5 request held while ungranted", rfsh_req, 1);
    chk(overdue == 1'b1, "R7 overdue after saturation", overdue, 1);
    win_on = 0;

    // drain the backlog
    gnt = 1'b1;
    win_falls = 0;
    win_on = 1;
    repeat (LIM * (SEQ_LEN + 1) + 2) @(negedge clk);
    chk(win_falls >= LIM, "R6 backlog serviced", win_falls, LIM);
    chk(overdue == 1'b1, "R7 overdue stays set", overdue, 1);
    win_on = 0;

    // irregular grants
    for (int i = 0; i < 600; i++) begin
      gnt = ($urandom_range(0, 3) == 0);
      @(negedge clk);
    end
    gnt = 1'b1;
    repeat (2 * INTV) @(negedge clk);

    chk(lo_max == RASL, "R4 RAS low run length", lo_max, RASL);
    chk(init_done == 1'b1, "R2 init_done held", init_done, 1);
    finish_run();
  end

endmodule